// File: doc/BRIEF.md
# Load/Store-Multiple Transfer Sequencer

This block turns one decoded load/store-multiple instruction word into a string of single-word memory transfers. It serves a load/store machine with 32 registers of 32 bits. The instruction carries a 16-bit register bitmap. A half-select bit maps that bitmap onto either the lower sixteen or the upper sixteen entries of the register file. The sequencer visits the set bits from lowest to highest and issues one transfer per granted cycle. For each transfer it drives the word address, the register index and the direction.

The addressing flags choose one of four layouts around the base value. Registers always go out in ascending index order, with the lowest register at the lowest address. When the word requests writeback, the sequencer presents the updated base value, along with the base register number, one cycle after the last transfer.

The instruction and the base value come in through a start/ready handshake. A memory grant input can stall any transfer without losing the bitmap position.

Top module: `lsm_seq`

## Requirements
- R1: `start_ready` is high only while the sequencer is idle. A word is accepted on a rising edge where both `start_valid` and `start_ready` are high. `start_valid` has no effect while `start_ready` is low.
- R2: An accepted word is illegal when bits 31:29 are not 3'b100, or when bits 8:7 are not both zero. In that case `illegal` is high for exactly the cycle after acceptance. No transfer, `done` or writeback follows, and the block is idle again in the next cycle.
- R3: The bitmap is {instr[18:9], instr[5:0]}. Bitmap bit i selects register i when instr[6] is 0, and register 16+i when instr[6] is 1. `rf_idx` carries that 5-bit register number.
- R4: Exactly one transfer is issued for each set bitmap bit, in ascending register order. A transfer completes on a rising edge where `mem_req` and `mem_gnt` are both high. The first request is presented in the cycle after acceptance.
- R5: With n set bits and base B, the first address is chosen by P (bit 28) and U (bit 27): B+4 for P=1,U=1; B for P=0,U=1; B−4n for P=1,U=0; B−4n+4 for P=0,U=0.
- R6: Each completed transfer moves the next request's address up by 4.
- R7: L (bit 24) sets the direction. L=1 loads: `mem_we`=0 and `rf_wr`=1. L=0 stores: `mem_we`=1 and `rf_rd`=1. `rf_wr` and `rf_rd` are valid only while `mem_req` is high.
- R8: While `mem_gnt` is low, `mem_req`, `mem_addr`, `rf_idx` and the direction hold their values.
- R9: `done` is high for one cycle, in the cycle after the last transfer completes. In that cycle `wb_valid` equals W (bit 24+1 = bit 25). `wb_idx` is instr[23:19]. `wb_val` is B+4n when U=1 and B−4n when U=0.
- R10: A legal word with an all-zero bitmap raises no `mem_req`. It raises `done` in the cycle after acceptance, with `wb_val` equal to B.
- R11: During reset and in the first cycle after it, the block is idle: `start_ready` is 1, and `mem_req`, `done`, `wb_valid` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Instruction word offered |
| start_ready | output | 1 | Sequencer idle, word can be taken |
| instr | input | 32 | Load/store-multiple instruction word |
| base_val | input | XLEN | Current value of the base register |
| mem_req | output | 1 | Transfer request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | XLEN | Word address of the transfer |
| mem_we | output | 1 | 1 for a store, 0 for a load |
| rf_idx | output | 5 | Register number of the transfer |
| rf_wr | output | 1 | Register file is written (load) |
| rf_rd | output | 1 | Register file is read (store) |
| done | output | 1 | Instruction finished |
| wb_valid | output | 1 | Base writeback requested |
| wb_idx | output | 5 | Base register number |
| wb_val | output | XLEN | Updated base value |
| illegal | output | 1 | Word rejected as malformed |

## Verification
The two activities that can share a cycle are the grant of the final transfer and a new word waiting at the start port. The bench offers the next instruction while the current one is still running, so `start_valid` stays high through the last grant and the `done` cycle. A cycle-by-cycle reference model decides on which edge the waiting word may be taken, and what the transfer stream, `done` and writeback must look like. Every output is compared against that model on every clock. Random grant stalls are applied so that the final grant and the `done` cycle land at different distances from the moment the word is offered.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   localparam int LSM_MAP_W = 16;
   localparam int LSM_POS_W = $clog2(LSM_MAP_W);
   localparam int LSM_IDX_W = LSM_POS_W + 1;
   localparam int LSM_CNT_W = $clog2(LSM_MAP_W + 1);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2,
      ST_BAD  = 2'd3
   } lsm_state_e;

   typedef struct packed {
      logic                 legal;
      logic                 pre;
      logic                 up;
      logic                 wback;
      logic                 load;
      logic [4:0]           rn;
      logic                 upper;
      logic [LSM_MAP_W-1:0] map;
   } lsm_fields_t;

endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
   import lsm_pkg::*;
(
   input  logic [31:0]  instr,
   output lsm_fields_t  fld
);
   logic lsm_unused_priv;

   assign lsm_unused_priv = instr[26];

   always_comb begin
      fld.legal = (instr[31:29] == 3'b100) && (instr[8:7] == 2'b00);
      fld.pre   = instr[28];
      fld.up    = instr[27];
      fld.wback = instr[25];
      fld.load  = instr[24];
      fld.rn    = instr[23:19];
      fld.upper = instr[6];
      fld.map   = {instr[18:9], instr[5:0]};
   end
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
   import lsm_pkg::*;
#(
   parameter int XLEN = 32
)(
   input  logic [LSM_MAP_W-1:0] map,
   input  logic                 pre,
   input  logic                 up,
   input  logic [XLEN-1:0]      base,
   output logic [XLEN-1:0]      first_addr,
   output logic [XLEN-1:0]      final_base
);
   logic [LSM_CNT_W-1:0] cnt;
   logic [XLEN-1:0]      span;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < LSM_MAP_W; i++)
         cnt = cnt + LSM_CNT_W'(map[i]);
   end

   assign span = XLEN'(cnt) << 2;

   always_comb begin
      unique case ({pre, up})
         2'b11:   first_addr = base + XLEN'(4);
         2'b01:   first_addr = base;
         2'b10:   first_addr = base - span;
         default: first_addr = base - span + XLEN'(4);
      endcase
      final_base = up ? (base + span) : (base - span);
   end
endmodule

// File: rtl/lsm_pick.sv
module lsm_pick #(
   parameter int W         = 16,
   parameter bit FIND_TREE = 1'b0,
   localparam int IW       = $clog2(W)
)(
   input  logic [W-1:0]  mask,
   output logic [IW-1:0] idx,
   output logic [W-1:0]  rest
);
   generate
      if (FIND_TREE) begin : g_iso
         logic [W-1:0] iso;
         assign iso  = mask & (~mask + W'(1));
         assign rest = mask & ~iso;
         always_comb begin
            idx = '0;
            for (int i = 0; i < W; i++)
               if (iso[i]) idx = idx | IW'(i);
         end
      end else begin : g_prio
         always_comb begin
            idx = '0;
            for (int i = W - 1; i >= 0; i--)
               if (mask[i]) idx = IW'(i);
         end
         assign rest = mask & ~(W'(1) << idx);
      end
   endgenerate
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
   import lsm_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit FIND_TREE = 1'b0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_valid,
   output logic                 start_ready,
   input  logic [31:0]          instr,
   input  logic [XLEN-1:0]      base_val,
   output logic                 mem_req,
   input  logic                 mem_gnt,
   output logic [XLEN-1:0]      mem_addr,
   output logic                 mem_we,
   output logic [LSM_IDX_W-1:0] rf_idx,
   output logic                 rf_wr,
   output logic                 rf_rd,
   output logic                 done,
   output logic                 wb_valid,
   output logic [4:0]           wb_idx,
   output logic [XLEN-1:0]      wb_val,
   output logic                 illegal
);
   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("lsm_seq: XLEN must be at least 32");
      end
      if (LSM_IDX_W != 5) begin : g_bad_idx
         $error("lsm_seq: register index must be 5 bits");
      end
   endgenerate

   lsm_fields_t          fld;
   logic [XLEN-1:0]      plan_first;
   logic [XLEN-1:0]      plan_final;
   logic [LSM_POS_W-1:0] pick_pos;
   logic [LSM_MAP_W-1:0] pick_rest;

   lsm_state_e           st_q;
   logic [LSM_MAP_W-1:0] mask_q;
   logic                 upper_q;
   logic                 store_q;
   logic                 wb_en_q;
   logic [4:0]           rn_q;
   logic [XLEN-1:0]      addr_q;
   logic [XLEN-1:0]      fin_q;

   lsm_decode u_dec (
      .instr (instr),
      .fld   (fld)
   );

   lsm_addr_plan #(.XLEN(XLEN)) u_plan (
      .map        (fld.map),
      .pre        (fld.pre),
      .up         (fld.up),
      .base       (base_val),
      .first_addr (plan_first),
      .final_base (plan_final)
   );

   lsm_pick #(.W(LSM_MAP_W), .FIND_TREE(FIND_TREE)) u_pick (
      .mask (mask_q),
      .idx  (pick_pos),
      .rest (pick_rest)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         mask_q  <= '0;
         upper_q <= 1'b0;
         store_q <= 1'b0;
         wb_en_q <= 1'b0;
         rn_q    <= '0;
         addr_q  <= '0;
         fin_q   <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_valid) begin
               mask_q  <= fld.map;
               upper_q <= fld.upper;
               store_q <= ~fld.load;
               wb_en_q <= fld.wback;
               rn_q    <= fld.rn;
               addr_q  <= plan_first;
               fin_q   <= plan_final;
               if (!fld.legal)
                  st_q <= ST_BAD;
               else if (fld.map == '0)
                  st_q <= ST_FIN;
               else
                  st_q <= ST_RUN;
            end
            ST_RUN: if (mem_gnt) begin
               mask_q <= pick_rest;
               addr_q <= addr_q + XLEN'(4);
               if (pick_rest == '0)
                  st_q <= ST_FIN;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign start_ready = (st_q == ST_IDLE);
   assign mem_req     = (st_q == ST_RUN);
   assign mem_addr    = addr_q;
   assign mem_we      = store_q;
   assign rf_idx      = {upper_q, pick_pos};
   assign rf_wr       = mem_req & ~store_q;
   assign rf_rd       = mem_req & store_q;
   assign done        = (st_q == ST_FIN);
   assign wb_valid    = done & wb_en_q;
   assign wb_idx      = rn_q;
   assign wb_val      = fin_q;
   assign illegal     = (st_q == ST_BAD);
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
   parameter int XLEN = 32
)(
   input logic            clk,
   input logic            rst_n,
   input logic            start_ready,
   input logic            mem_req,
   input logic            mem_gnt,
   input logic [XLEN-1:0] mem_addr,
   input logic            mem_we,
   input logic [4:0]      rf_idx,
   input logic            done,
   input logic            wb_valid,
   input logic            illegal
);
   a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || done || illegal) |-> !start_ready);

   a_r2_illegal_alone: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!done && !mem_req && !wb_valid));

   a_r2_illegal_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> (!illegal && start_ready));

   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(rf_idx)
                                 && $stable(mem_we)));

   a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> (!mem_req || mem_addr == $past(mem_addr) + XLEN'(4)));

   a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> (!mem_req || rf_idx > $past(rf_idx)));

   a_r3_same_half: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> (!mem_req || rf_idx[4] == $past(rf_idx[4])));

   a_r9_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> (mem_req || done));

   a_r9_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done);
endmodule

bind lsm_seq lsm_seq_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_lsm_seq.sv
module sim_lsm_seq;
   localparam int XLEN = 32;

   typedef struct {
      logic [31:0] addr;
      logic [4:0]  idx;
      logic        we;
   } xfer_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [31:0]     base_val = '0;
   logic            mem_gnt = 1'b1;
   logic            start_ready, mem_req, mem_we, rf_wr, rf_rd, done, wb_valid, illegal;
   logic [31:0]     mem_addr, wb_val;
   logic [4:0]      rf_idx, wb_idx;

   int checks = 0;
   int failures = 0;
   int gnt_mode = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lsm_seq #(.XLEN(XLEN)) u0 (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
      .instr(instr), .base_val(base_val), .mem_req(mem_req), .mem_gnt(mem_gnt),
      .mem_addr(mem_addr), .mem_we(mem_we), .rf_idx(rf_idx), .rf_wr(rf_wr),
      .rf_rd(rf_rd), .done(done), .wb_valid(wb_valid), .wb_idx(wb_idx),
      .wb_val(wb_val), .illegal(illegal)
   );

   // ---------------- reference model ----------------
   xfer_t       q[$];
   bit          m_busy = 0, m_fin = 0, m_bad = 0, m_zero = 0, m_stalled = 0, m_first = 0;
   bit          m_wb = 0;
   logic [4:0]  m_rn = '0;
   logic [31:0] m_wbval = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_busy = 0; m_fin = 0; m_bad = 0; m_stalled = 0; m_first = 0;
      end else begin
         bit was_idle;
         was_idle = !m_busy && !m_fin && !m_bad;
         m_fin = 0;
         m_bad = 0;
         m_stalled = 0;
         m_first = 0;
         if (m_busy) begin
            if (mem_gnt) begin
               void'(q.pop_front());
               if (q.size() == 0) begin
                  m_busy = 0;
                  m_fin = 1;
               end
            end else begin
               m_stalled = 1;
            end
         end
         if (was_idle && start_valid) begin
            if (instr[31:29] != 3'b100 || instr[8:7] != 2'b00) begin
               m_bad = 1;
            end else begin
               logic [15:0] map;
               int          n;
               logic [31:0] lo;
               map = {instr[18:9], instr[5:0]};
               n = $countones(map);
               if (instr[28] && instr[27])       lo = base_val + 4;
               else if (!instr[28] && instr[27]) lo = base_val;
               else if (instr[28])               lo = base_val - 4 * n;
               else                              lo = base_val - 4 * n + 4;
               m_wb = instr[25];
               m_rn = instr[23:19];
               m_wbval = instr[27] ? base_val + 4 * n : base_val - 4 * n;
               m_zero = (n == 0);
               for (int i = 0; i < 16; i++) begin
                  if (map[i]) begin
                     xfer_t t;
                     t.addr = lo;
                     t.idx = {instr[6], 4'(i)};
                     t.we = ~instr[24];
                     q.push_back(t);
                     lo = lo + 4;
                  end
               end
               if (n == 0) m_fin = 1;
               else begin
                  m_busy = 1;
                  m_first = 1;
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp, input string what);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit exp_ready;
         exp_ready = !m_busy && !m_fin && !m_bad;
         chk(start_ready == exp_ready, "R1", 32'(start_ready), 32'(exp_ready), "start_ready");
         chk(illegal == m_bad, "R2", 32'(illegal), 32'(m_bad), "illegal");
         chk(mem_req == m_busy, m_zero ? "R10" : "R4", 32'(mem_req), 32'(m_busy), "mem_req");
         if (m_busy && mem_req) begin
            string atag;
            atag = m_stalled ? "R8" : (m_first ? "R5" : "R6");
            chk(mem_addr == q[0].addr, atag, mem_addr, q[0].addr, "mem_addr");
            chk(rf_idx == q[0].idx, m_stalled ? "R8" : "R3", 32'(rf_idx), 32'(q[0].idx), "rf_idx");
            chk(mem_we == q[0].we && rf_rd == q[0].we && rf_wr == !q[0].we, "R7",
                {29'd0, mem_we, rf_rd, rf_wr}, {29'd0, q[0].we, q[0].we, !q[0].we}, "direction");
         end
         chk(done == m_fin, m_zero ? "R10" : "R9", 32'(done), 32'(m_fin), "done");
         chk(wb_valid == (m_fin && m_wb), "R9", 32'(wb_valid), 32'(m_fin && m_wb), "wb_valid");
         if (m_fin) begin
            chk(wb_val == m_wbval, m_zero ? "R10" : "R9", wb_val, m_wbval, "wb_val");
            chk(wb_idx == m_rn, "R9", 32'(wb_idx), 32'(m_rn), "wb_idx");
         end
      end
   end

   // grant driver
   always @(posedge clk) begin
      #2;
      if (gnt_mode == 0) mem_gnt = 1'b1;
      else               mem_gnt = ($urandom_range(0, 99) < 55);
   end

   function automatic logic [31:0] mk(input bit p, input bit u, input bit w, input bit l,
                                      input logic [4:0] rn, input bit h, input logic [15:0] map,
                                      input logic [1:0] pad = 2'b00,
                                      input logic [2:0] cls = 3'b100);
      return {cls, p, u, 1'b0, w, l, rn, map[15:6], pad, h, map[5:0]};
   endfunction

   task automatic issue(input logic [31:0] w, input logic [31:0] b);
      bit r;
      @(posedge clk); #2;
      instr = w;
      base_val = b;
      start_valid = 1'b1;
      forever begin
         @(negedge clk);
         r = start_ready;
         @(posedge clk); #2;
         if (r) break;
      end
      start_valid = 1'b0;
      instr = $urandom;
      base_val = $urandom;
   endtask

   task automatic settle();
      repeat (40) @(posedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      // R11 reset state
      #23;
      chk(start_ready == 1'b1, "R11", 32'(start_ready), 32'd1, "start_ready in reset");
      chk(!mem_req && !done && !wb_valid && !illegal, "R11",
          {28'd0, mem_req, done, wb_valid, illegal}, 32'd0, "outputs in reset");
      @(posedge clk); #2;
      rst_n = 1'b1;
      @(negedge clk);
      chk(start_ready == 1'b1 && !mem_req, "R11", 32'(start_ready), 32'd1, "idle after reset");

      // R5/R7: load, P=1 U=1, lower half
      issue(mk(1, 1, 1, 1, 5'd3, 0, 16'h8421), 32'h0000_1000);
      settle();
      // R5: store, P=0 U=0, upper half, writeback
      issue(mk(0, 0, 1, 0, 5'd17, 1, 16'h00F0), 32'h0000_2000);
      settle();
      // R5: P=1 U=0 and P=0 U=1
      issue(mk(1, 0, 1, 1, 5'd31, 1, 16'h0303), 32'h0000_3000);
      settle();
      issue(mk(0, 1, 0, 0, 5'd0, 0, 16'h4001), 32'h0000_4000);
      settle();
      // R10: empty bitmap
      issue(mk(1, 1, 1, 1, 5'd9, 0, 16'h0000), 32'h0000_5000);
      settle();
      issue(mk(0, 0, 1, 0, 5'd9, 1, 16'h0000), 32'h0000_5100);
      settle();
      // R2: padding bits and class mismatch
      issue(mk(1, 1, 1, 1, 5'd2, 0, 16'h00FF, 2'b01), 32'h0000_6000);
      settle();
      issue(mk(1, 1, 1, 1, 5'd2, 0, 16'h00FF, 2'b00, 3'b101), 32'h0000_6100);
      settle();
      // full and single-bit maps
      issue(mk(1, 0, 1, 0, 5'd13, 1, 16'hFFFF), 32'h0001_0000);
      settle();
      issue(mk(0, 1, 1, 1, 5'd20, 1, 16'h8000), 32'h0000_7000);
      settle();
      // R1/R8: back-to-back words under random grant stalls
      gnt_mode = 1;
      for (int k = 0; k < 60; k++) begin
         logic [15:0] mp;
         mp = (k % 9 == 0) ? 16'h0000 : 16'($urandom);
         issue(mk(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom),
                  1'($urandom), mp, (k % 11 == 5) ? 2'b10 : 2'b00), $urandom & 32'hFFFF_FFFC);
      end
      settle();
      summary();
   end
endmodule